// File: doc/BRIEF.md
# Page write latch and timer

This block sits behind a two-wire bus slave controller in a serial memory. During a write transaction it gathers between one and thirty-two data bytes that all belong to one 32-byte row of the storage array. When the transaction ends correctly, it commits them in a single self-timed write cycle. The controller gives it the starting address of the transaction and one strobe per received data byte. It also reports every stop condition, with a flag that says whether the stop fell in the bit slot right after the acknowledge of a data byte.

A 5-bit in-row offset selects the latch slot for each accepted byte. The offset wraps inside the row and never carries into the row bits. A qualifying stop raises `busy` for a fixed number of clock cycles. The controller uses `busy` to refuse bus traffic during that time. When the window ends, every latch slot marked valid is written into the array model, and the shared address counter moves to the byte after the last one written. Any other stop throws the pending bytes away.

The array model holds 2^MEM_AW bytes. The row number is fill address bits MEM_AW-1 down to 5, which is bits 12 to 5 when MEM_AW is 13. The default is kept smaller. A combinational read port exposes the array contents.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy` is 0, `fill_addr` and `cur_addr` are 0, and every array byte reads 0xFF on `rd_data`.
- R2: An `addr_load` pulse while not busy loads `addr_in` into both `fill_addr` and `cur_addr` on the next cycle, and marks every latch slot invalid. Bytes latched before it are never committed. Within one cycle the priority is `addr_load`, then `stop_evt`, then `byte_stb`.
- R3: A `byte_stb` with `wr_lock` low and not busy is accepted. The byte goes into the latch slot given by `fill_addr[4:0]`. On the next cycle `fill_addr[4:0]` has grown by one modulo 32, and `fill_addr[15:5]` is unchanged.
- R4: More than 32 accepted bytes wrap to the start of the same row. The last byte written to a slot is the one committed.
- R5: A write cycle starts only on `stop_evt` with `stop_ack_slot` high, when the latest data-byte event since the last address load was an accepted byte. Any other stop discards all latched bytes and leaves `busy` low.
- R6: `busy` rises on the cycle after a qualifying stop and stays high for exactly WRITE_CYCLES cycles.
- R7: The array changes only on the cycle `busy` falls. Then exactly the slots holding accepted bytes are written, at address {row, slot}. All other bytes keep their values.
- R8: When `busy` falls, `cur_addr` equals `fill_addr`, the address after the last byte written within the row. A discarded write leaves `cur_addr` at the loaded address.
- R9: A data byte strobed while `wr_lock` is high is not latched and does not move `fill_addr`. A stop that follows it does not start a write cycle.
- R10: An address load followed by a stop with no data byte does not raise `busy`.
- R11: While `busy` is high, `addr_load`, `byte_stb` and `stop_evt` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Start of a write address phase, with `addr_in` valid |
| addr_in | input | 16 | Byte address received from the bus |
| byte_stb | input | 1 | One received data byte on `byte_in` |
| byte_in | input | 8 | Data byte |
| wr_lock | input | 1 | Write-control level; high blocks data bytes |
| stop_evt | input | 1 | Stop condition seen on the bus |
| stop_ack_slot | input | 1 | The stop fell in the slot right after a data-byte acknowledge |
| rd_addr | input | MEM_AW | Array read address |
| busy | output | 1 | Self-timed write cycle in progress |
| fill_addr | output | 16 | Write pointer: row bits plus wrapping in-row offset |
| cur_addr | output | 16 | Shared address counter |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The bound checker watches the port-level rules on every cycle:
- the in-row offset steps by one with the row bits held (R3);
- address loads reach both counters (R2);
- `busy` only rises after a qualifying stop (R5);
- every busy window is exactly WRITE_CYCLES long (R6);
- `fill_addr` is frozen while busy or after a locked byte (R9, R11);
- `cur_addr` meets `fill_addr` as the window closes (R8).

Only the bench scenarios can show what lands in the array: that wrapped bytes overwrite earlier ones, that slots never written stay untouched, that discarded and locked transactions leave memory at 0xFF, and that nothing is visible before the window closes. The bench checks these against a scoreboard of expected bytes.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    parameter int unsigned PWL_AW    = 16;          // bus address width
    parameter int unsigned PWL_OFS_W = 5;           // in-row offset width
    parameter int unsigned PWL_SLOTS = 1 << PWL_OFS_W;
    parameter int unsigned PWL_DW    = 8;

    typedef struct packed {
        logic [PWL_AW-1:0] fill;     // write pointer
        logic [PWL_AW-1:0] cur;      // shared address counter
        logic              last_ok;  // latest data event was an accepted byte
    } pwl_ctl_t;
endpackage

// File: rtl/pwl_row_latch.sv
module pwl_row_latch
    import pwl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              wr_en,
    input  logic [PWL_OFS_W-1:0]              wr_off,
    input  logic [PWL_DW-1:0]                 wr_data,
    output logic [PWL_SLOTS-1:0][PWL_DW-1:0]  slot_data,
    output logic [PWL_SLOTS-1:0]              slot_vld
);
    for (genvar s = 0; s < PWL_SLOTS; s++) begin : g_slot
        logic [PWL_DW-1:0] data_d, data_q;
        logic              vld_d, vld_q;
        logic              hit;

        always_comb begin
            hit    = wr_en && (wr_off == PWL_OFS_W'(s));
            data_d = data_q;
            vld_d  = vld_q;
            if (clr) begin
                vld_d = 1'b0;
            end else if (hit) begin
                data_d = wr_data;
                vld_d  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                data_q <= data_d;
                vld_q  <= vld_d;
            end
        end

        assign slot_data[s] = data_q;
        assign slot_vld[s]  = vld_q;
    end
endmodule

// File: rtl/pwl_timer.sv
module pwl_timer #(
    parameter int unsigned CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic          busy_d, busy_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        busy_d = busy_q;
        cnt_d  = cnt_q;
        if (start) begin
            busy_d = 1'b1;
            cnt_d  = CW'(CYCLES - 1);
        end else if (busy_q && cnt_q == '0) begin
            busy_d = 1'b0;
        end else if (busy_q) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= busy_d;
            cnt_q  <= cnt_d;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pwl_array.sv
module pwl_array
    import pwl_pkg::*;
#(
    parameter int unsigned MEM_AW = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [MEM_AW-PWL_OFS_W-1:0]       row,
    input  logic [PWL_SLOTS-1:0][PWL_DW-1:0]  slot_data,
    input  logic [PWL_SLOTS-1:0]              slot_vld,
    input  logic [MEM_AW-1:0]                 rd_addr,
    output logic [PWL_DW-1:0]                 rd_data
);
    localparam int unsigned DEPTH = 1 << MEM_AW;

    logic [PWL_DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '1;
        end else if (commit) begin
            for (int s = 0; s < PWL_SLOTS; s++) begin
                if (slot_vld[s]) mem_q[{row, PWL_OFS_W'(s)}] <= slot_data[s];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
    import pwl_pkg::*;
#(
    parameter int unsigned MEM_AW       = 9,
    parameter int unsigned WRITE_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [PWL_AW-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [PWL_DW-1:0] byte_in,
    input  logic              wr_lock,
    input  logic              stop_evt,
    input  logic              stop_ack_slot,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic              busy,
    output logic [PWL_AW-1:0] fill_addr,
    output logic [PWL_AW-1:0] cur_addr,
    output logic [PWL_DW-1:0] rd_data
);
    localparam int unsigned ROW_W = MEM_AW - PWL_OFS_W;
    localparam logic [PWL_OFS_W-1:0] OFS_ONE = PWL_OFS_W'(1);

    pwl_ctl_t st_d, st_q;
    logic     accept, cyc_start, cyc_done, lat_clr;
    logic [PWL_SLOTS-1:0][PWL_DW-1:0] slot_data;
    logic [PWL_SLOTS-1:0]             slot_vld;

    // next-state: busy blocks everything; load > stop > byte
    always_comb begin
        st_d      = st_q;
        accept    = 1'b0;
        cyc_start = 1'b0;
        lat_clr   = 1'b0;
        if (!busy) begin
            if (addr_load) begin
                st_d.fill    = addr_in;
                st_d.cur     = addr_in;
                st_d.last_ok = 1'b0;
                lat_clr      = 1'b1;
            end else if (stop_evt) begin
                st_d.last_ok = 1'b0;
                if (stop_ack_slot && st_q.last_ok) cyc_start = 1'b1;
                else                               lat_clr   = 1'b1;
            end else if (byte_stb) begin
                if (!wr_lock) begin
                    accept       = 1'b1;
                    st_d.fill    = {st_q.fill[PWL_AW-1:PWL_OFS_W],
                                    st_q.fill[PWL_OFS_W-1:0] + OFS_ONE};
                    st_d.last_ok = 1'b1;
                end else begin
                    st_d.last_ok = 1'b0;
                end
            end
        end
        if (cyc_done) begin
            st_d.cur = st_q.fill;
            lat_clr  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pwl_row_latch i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lat_clr),
        .wr_en     (accept),
        .wr_off    (st_q.fill[PWL_OFS_W-1:0]),
        .wr_data   (byte_in),
        .slot_data (slot_data),
        .slot_vld  (slot_vld)
    );

    pwl_timer #(.CYCLES(WRITE_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .busy  (busy),
        .done  (cyc_done)
    );

    pwl_array #(.MEM_AW(MEM_AW)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (cyc_done),
        .row       (st_q.fill[MEM_AW-1:PWL_OFS_W]),
        .slot_data (slot_data),
        .slot_vld  (slot_vld),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    assign fill_addr = st_q.fill;
    assign cur_addr  = st_q.cur;

    logic [ROW_W-1:0] unused_row_chk;
    assign unused_row_chk = st_q.fill[MEM_AW-1:PWL_OFS_W];
endmodule

// File: rtl/pwl_checker.sv
module pwl_checker
    import pwl_pkg::*;
#(
    parameter int unsigned WRITE_CYCLES = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load,
    input logic [PWL_AW-1:0] addr_in,
    input logic              byte_stb,
    input logic              wr_lock,
    input logic              stop_evt,
    input logic              stop_ack_slot,
    input logic              busy,
    input logic [PWL_AW-1:0] fill_addr,
    input logic [PWL_AW-1:0] cur_addr
);
    localparam int unsigned RW = $clog2(WRITE_CYCLES + 2);

    logic [RW-1:0] run_q;
    logic          took;

    assign took = byte_stb && !wr_lock && !addr_load && !stop_evt && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + RW'(1);
        else           run_q <= '0;
    end

    // R2: an address load reaches both counters
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && !busy) |=> (fill_addr == $past(addr_in)) && (cur_addr == $past(addr_in)));

    // R3: offset steps by one, row bits held
    p_offset_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (fill_addr[PWL_AW-1:PWL_OFS_W] == $past(fill_addr[PWL_AW-1:PWL_OFS_W]))
              && (fill_addr[PWL_OFS_W-1:0] == $past(fill_addr[PWL_OFS_W-1:0]) + PWL_OFS_W'(1)));

    // R5: busy only follows a stop in the acknowledge slot
    p_start_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt && stop_ack_slot && !addr_load));

    // R6: window length
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RW'(WRITE_CYCLES)));
    p_busy_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(WRITE_CYCLES)));

    // R8: shared counter meets the write pointer at completion
    p_cur_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cur_addr == fill_addr));

    // R9: a locked byte does not move the pointer
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && wr_lock && !addr_load && !stop_evt && !busy) |=> $stable(fill_addr));

    // R11: pointer frozen while busy
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fill_addr));
endmodule

bind page_commit_unit pwl_checker #(.WRITE_CYCLES(WRITE_CYCLES)) i_pwl_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_load     (addr_load),
    .addr_in       (addr_in),
    .byte_stb      (byte_stb),
    .wr_lock       (wr_lock),
    .stop_evt      (stop_evt),
    .stop_ack_slot (stop_ack_slot),
    .busy          (busy),
    .fill_addr     (fill_addr),
    .cur_addr      (cur_addr)
);

// File: tb/test_page_commit_unit.sv
module test_page_commit_unit;
    localparam int unsigned MEM_AW = 9;
    localparam int unsigned WCYC   = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_load = 1'b0;
    logic [15:0]       addr_in = '0;
    logic              byte_stb = 1'b0;
    logic [7:0]        byte_in = '0;
    logic              wr_lock = 1'b0;
    logic              stop_evt = 1'b0;
    logic              stop_ack_slot = 1'b0;
    logic [MEM_AW-1:0] rd_addr = '0;
    logic              busy;
    logic [15:0]       fill_addr, cur_addr;
    logic [7:0]        rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [MEM_AW-1:0] a;
        logic [7:0]        d;
        string             req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    page_commit_unit #(.MEM_AW(MEM_AW), .WRITE_CYCLES(WCYC)) i_page_commit_unit (
        .clk, .rst_n, .addr_load, .addr_in, .byte_stb, .byte_in, .wr_lock,
        .stop_evt, .stop_ack_slot, .rd_addr, .busy, .fill_addr, .cur_addr, .rd_data
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // driver side: expected array contents go to the scoreboard
    task automatic expect_mem(logic [MEM_AW-1:0] a, logic [7:0] d, string req);
        exp_t it;
        it.a = a; it.d = d; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        #3;
    endtask

    // monitor: pops expectations and compares the array read port
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                exp_t it;
                it = exp_q.pop_front();
                rd_addr = it.a;
                #1;
                chk(it.req, 32'(rd_data), 32'(it.d));
            end
        end
    end

    task automatic load(logic [15:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic send(logic [7:0] d, logic lock);
        byte_stb = 1'b1; byte_in = d; wr_lock = lock;
        @(negedge clk);
        byte_stb = 1'b0; wr_lock = 1'b0;
    endtask

    task automatic stop(logic in_slot);
        stop_evt = 1'b1; stop_ack_slot = in_slot;
        @(negedge clk);
        stop_evt = 1'b0; stop_ack_slot = 1'b0;
    endtask

    task automatic busy_window(string req);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(req, 32'(n), 32'(WCYC));
    endtask

    task automatic stay_idle(string req);
        repeat (3) begin
            chk(req, 32'(busy), 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 cur_addr", 32'(cur_addr), 0);
        chk("R1 fill_addr", 32'(fill_addr), 0);
        expect_mem(9'h000, 8'hFF, "R1 mem");
        expect_mem(9'h005, 8'hFF, "R1 mem");
        expect_mem(9'h1FF, 8'hFF, "R1 mem");
        drain();

        // R2 / R3: single byte write and commit
        load(16'h0123);
        chk("R2 fill load", 32'(fill_addr), 32'h0123);
        chk("R2 cur load", 32'(cur_addr), 32'h0123);
        send(8'hAA, 1'b0);
        chk("R3 step", 32'(fill_addr), 32'h0124);
        stop(1'b1);
        chk("R6 busy rises", 32'(busy), 1);
        expect_mem(9'h123, 8'hFF, "R7 unchanged during busy");
        busy_window("R6 busy length");
        drain();
        expect_mem(9'h123, 8'hAA, "R7 byte written");
        expect_mem(9'h124, 8'hFF, "R7 neighbour untouched");
        drain();
        chk("R8 cur after commit", 32'(cur_addr), 32'h0124);

        // R3 wrap inside row 1
        load(16'h003E);
        send(8'h10, 1'b0);
        send(8'h11, 1'b0);
        chk("R3 wrap no carry", 32'(fill_addr), 32'h0020);
        send(8'h12, 1'b0);
        send(8'h13, 1'b0);
        stop(1'b1);
        busy_window("R6 busy length");
        expect_mem(9'h03E, 8'h10, "R3 wrap data");
        expect_mem(9'h03F, 8'h11, "R3 wrap data");
        expect_mem(9'h020, 8'h12, "R3 wrap data");
        expect_mem(9'h021, 8'h13, "R3 wrap data");
        expect_mem(9'h022, 8'hFF, "R7 unwritten slot");
        expect_mem(9'h040, 8'hFF, "R3 next row untouched");
        drain();
        chk("R8 cur after wrap", 32'(cur_addr), 32'h0022);

        // R4: 33 bytes overwrite slot 0
        load(16'h0040);
        for (int i = 0; i < 33; i++) send(8'(i), 1'b0);
        chk("R4 pointer", 32'(fill_addr), 32'h0041);
        stop(1'b1);
        busy_window("R6 busy length");
        expect_mem(9'h040, 8'h20, "R4 overwrite");
        expect_mem(9'h041, 8'h01, "R4 slot1");
        expect_mem(9'h05F, 8'h1F, "R4 slot31");
        drain();
        chk("R8 cur after overwrite", 32'(cur_addr), 32'h0041);

        // R5: stop outside the acknowledge slot discards
        load(16'h0080);
        send(8'h55, 1'b0);
        stop(1'b0);
        stay_idle("R5 no cycle");
        stop(1'b1);
        stay_idle("R5 discarded stays idle");
        expect_mem(9'h080, 8'hFF, "R5 discarded");
        drain();
        chk("R8 cur after discard", 32'(cur_addr), 32'h0080);

        // R10: zero-byte write
        load(16'h00A0);
        stop(1'b1);
        stay_idle("R10 no busy");

        // R9: locked byte
        load(16'h00C0);
        send(8'h77, 1'b1);
        chk("R9 pointer held", 32'(fill_addr), 32'h00C0);
        stop(1'b1);
        stay_idle("R9 no cycle");
        expect_mem(9'h0C0, 8'hFF, "R9 not written");
        drain();

        // R9: accepted byte then locked byte
        load(16'h00D0);
        send(8'h44, 1'b0);
        send(8'h45, 1'b1);
        chk("R9 pointer after mix", 32'(fill_addr), 32'h00D1);
        stop(1'b1);
        stay_idle("R9 mixed no cycle");
        expect_mem(9'h0D0, 8'hFF, "R9 mixed not written");
        drain();

        // R2: new address phase drops earlier bytes
        load(16'h0180);
        send(8'hA1, 1'b0);
        load(16'h0185);
        send(8'hB2, 1'b0);
        stop(1'b1);
        busy_window("R6 busy length");
        expect_mem(9'h180, 8'hFF, "R2 dropped byte");
        expect_mem(9'h185, 8'hB2, "R2 new byte");
        drain();

        // R11: inputs ignored while busy
        load(16'h0100);
        send(8'h99, 1'b0);
        stop(1'b1);
        addr_load = 1'b1; addr_in = 16'h01E0;
        byte_stb = 1'b1; byte_in = 8'h66;
        stop_evt = 1'b1; stop_ack_slot = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R11 fill frozen", 32'(fill_addr), 32'h0101);
        end
        addr_load = 1'b0; byte_stb = 1'b0; stop_evt = 1'b0; stop_ack_slot = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R11 busy ended", 32'(busy), 0);
        chk("R11 cur after", 32'(cur_addr), 32'h0101);
        expect_mem(9'h100, 8'h99, "R11 committed");
        expect_mem(9'h101, 8'hFF, "R11 ignored byte");
        expect_mem(9'h1E0, 8'hFF, "R11 ignored load");
        drain();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule